// File: doc/BRIEF.md
# Selectable-Order Burst Address Generator

This block supplies the word address for each of the four beats of a memory burst. A burst begins when either of two active-low address strobes is sampled low: the 17-bit start address is captured, and the beat counter is cleared. After that, each clock edge that samples the active-low advance input low and both strobes high moves the burst to its next beat. Only the two least significant address bits move. The upper bits stay at their captured value.

The order of the beats is fixed when the burst starts, by a mode input. Linear order adds the beat number to the start's low bits, modulo four. Interleaved order XORs the beat number into them. A flag marks the fourth beat. One more advance after that beat wraps the burst back to its start address. A strobe always takes priority: it restarts the burst from the new address, even in the middle of a burst.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, beat_addr is 0 and last_beat is 0.
- R2: An edge that samples strobe_p_n or strobe_c_n low makes beat_addr equal the sampled start_addr, with last_beat 0, from the next cycle.
- R3: After a burst has started, an edge that samples advance_n low and both strobes high moves the burst one beat forward, with beat number k counting 0,1,2,3,0.
- R4: An edge that samples advance_n high and both strobes high leaves beat_addr and last_beat unchanged.
- R5: When order_interleave was 0 at the start edge (linear), beat_addr[1:0] = (start[1:0] + k) mod 4.
- R6: When order_interleave was 1 at the start edge (interleaved), beat_addr[1:0] = start[1:0] XOR k.
- R7: During a burst, beat_addr[16:2] equals start_addr[16:2] as captured at the start edge.
- R8: last_beat is 1 exactly when a burst is on beat k = 3. One more advance returns beat_addr to the start address and clears last_beat.
- R9: A strobe sampled together with advance_n low restarts the burst from the new start_addr. The advance does not apply.
- R10: Advances before the first strobe after reset have no effect. beat_addr stays 0.
- R11: A change of order_interleave after the start edge does not change the order of the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| strobe_p_n | input | 1 | Processor-side address strobe, active low |
| strobe_c_n | input | 1 | Controller-side address strobe, active low |
| advance_n | input | 1 | Step to next beat, active low |
| order_interleave | input | 1 | 1 = interleaved order, 0 = linear order; sampled with a strobe |
| start_addr | input | 17 | Burst start address |
| beat_addr | output | 17 | Address of the current beat |
| last_beat | output | 1 | High on the fourth beat of a burst |

## Verification
A corrupted beat counter appears on beat_addr[1:0] in the cycle after the faulty advance. The same fault usually moves last_beat to the wrong beat as well. If the wrong order was latched, the first advance shows it only for starts whose low bits differ between the two orders (odd starts at beat 1). For that reason every start value is run in both orders. A bad copy of the captured base shows on the upper bits directly after the strobe edge. A missed wrap shows one advance after last_beat.

// File: rtl/ba_pkg.sv
package ba_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;

  function automatic beat_t lin_low(input beat_t s, input beat_t k);
    return beat_t'(s + k);
  endfunction

  function automatic beat_t ilv_low(input beat_t s, input beat_t k);
    return s ^ k;
  endfunction
endpackage

// File: rtl/ba_start_reg.sv
module ba_start_reg #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] start_in,
  input  logic          mode_in,
  output logic [AW-1:0] base_q,
  output logic          mode_q,
  output logic          live_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      mode_q <= 1'b0;
      live_q <= 1'b0;
    end else if (load) begin
      base_q <= start_in;
      mode_q <= mode_in;
      live_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ba_beat_ctr.sv
module ba_beat_ctr
  import ba_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  logic  step,
  output beat_t cnt_q,
  output logic  wrap
);
  assign wrap = step && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (rst || load) cnt_q <= '0;
    else if (step)   cnt_q <= beat_t'(cnt_q + 1'b1);
  end
endmodule

// File: rtl/ba_low_mix.sv
module ba_low_mix
  import ba_pkg::*;
#(
  parameter bit HAS_INTERLEAVE = 1'b1
) (
  input  beat_t base_low,
  input  beat_t cnt,
  input  logic  mode,
  output beat_t low
);
  generate
    if (HAS_INTERLEAVE) begin : g_both
      assign low = mode ? ilv_low(base_low, cnt) : lin_low(base_low, cnt);
    end else begin : g_lin
      logic unused_mode;
      assign unused_mode = mode;
      assign low = lin_low(base_low, cnt);
    end
  endgenerate
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import ba_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe_p_n,
  input  logic          strobe_c_n,
  input  logic          advance_n,
  input  logic          order_interleave,
  input  logic [AW-1:0] start_addr,
  output logic [AW-1:0] beat_addr,
  output logic          last_beat
);
  localparam int UPPER_W = AW - BEAT_W;

  logic          load_evt;
  logic          step_evt;
  logic          wrap_evt;
  logic [AW-1:0] base_q;
  logic          mode_q;
  logic          live_q;
  beat_t         cnt_q;
  beat_t         low_bits;

  assign load_evt = !strobe_p_n || !strobe_c_n;
  assign step_evt = !load_evt && !advance_n && live_q;

  ba_start_reg #(.AW(AW)) u_start (
    .clk(clk), .rst(rst), .load(load_evt), .start_in(start_addr),
    .mode_in(order_interleave), .base_q(base_q), .mode_q(mode_q), .live_q(live_q)
  );

  ba_beat_ctr u_ctr (
    .clk(clk), .rst(rst), .load(load_evt), .step(step_evt),
    .cnt_q(cnt_q), .wrap(wrap_evt)
  );

  ba_low_mix #(.HAS_INTERLEAVE(1'b1)) u_mix (
    .base_low(base_q[BEAT_W-1:0]), .cnt(cnt_q), .mode(mode_q), .low(low_bits)
  );

  logic [UPPER_W-1:0] upper_bits;
  assign upper_bits = base_q[AW-1:BEAT_W];
  assign beat_addr  = {upper_bits, low_bits};
  assign last_beat  = live_q && (cnt_q == '1);
endmodule

// File: rtl/ba_checker.sv
module ba_checker #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          strobe_p_n,
  input logic          strobe_c_n,
  input logic          advance_n,
  input logic [AW-1:0] start_addr,
  input logic [AW-1:0] beat_addr,
  input logic          last_beat,
  input logic          load_evt,
  input logic          wrap_evt
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (beat_addr == '0 && !last_beat));

  a_r2_load_start: assert property (@(posedge clk) disable iff (rst)
    (!strobe_p_n || !strobe_c_n) |=> (beat_addr == $past(start_addr) && !last_beat));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (strobe_p_n && strobe_c_n && advance_n) |=> ($stable(beat_addr) && $stable(last_beat)));

  a_r7_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    (strobe_p_n && strobe_c_n) |=> (beat_addr[AW-1:2] == $past(beat_addr[AW-1:2])));

  a_r8_wrap_clears: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |-> last_beat);

  a_r8_after_last: assert property (@(posedge clk) disable iff (rst)
    (last_beat && strobe_p_n && strobe_c_n && !advance_n) |=> !last_beat);

  a_r9_strobe_wins: assert property (@(posedge clk) disable iff (rst)
    load_evt |-> !wrap_evt);
endmodule

bind burst_addr_gen ba_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n),
  .advance_n(advance_n), .start_addr(start_addr), .beat_addr(beat_addr),
  .last_beat(last_beat), .load_evt(load_evt), .wrap_evt(wrap_evt)
);

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int CLK_P = 10;
  localparam int AW = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sp_n = 1'b1, sc_n = 1'b1, adv_n = 1'b1, mode = 1'b0;
  logic [AW-1:0] sa = '0;
  logic [AW-1:0] ba;
  logic lb;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  burst_addr_gen #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .strobe_p_n(sp_n), .strobe_c_n(sc_n),
    .advance_n(adv_n), .order_interleave(mode), .start_addr(sa),
    .beat_addr(ba), .last_beat(lb)
  );

  // expected address from requirements R5/R6/R7
  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] s, input int k, input bit ilv);
    int lo;
    lo = ilv ? (int'(s[1:0]) ^ k) : ((int'(s[1:0]) + k) % 4);
    return {s[AW-1:2], 2'(lo)};
  endfunction

  task automatic chk(input string req, input logic [AW-1:0] a_exp, input bit l_exp);
    checks++;
    if (ba !== a_exp || lb !== l_exp) begin
      errors++;
      $display("FAIL %s: addr %h last %b, expected addr %h last %b", req, ba, lb, a_exp, l_exp);
    end
  endtask

  // drive at negedge, sample 1 time unit after next posedge
  task automatic cyc(input bit p, input bit c, input bit a, input bit m, input logic [AW-1:0] s);
    @(negedge clk);
    sp_n = p; sc_n = c; adv_n = a; mode = m; sa = s;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    cyc(1, 1, 1, 0, '0);
    chk("R1", '0, 0);
    rst = 1'b0;
    cyc(1, 1, 1, 0, 17'h1FFFF);
    chk("R1", '0, 0);
  endtask

  task automatic t_idle_advance();
    for (int i = 0; i < 3; i++) begin
      cyc(1, 1, 0, 1, 17'h12345);
      chk("R10", '0, 0);
    end
  endtask

  task automatic t_burst(input logic [AW-1:0] s, input bit ilv, input bit use_c, input bit flip);
    string rq;
    rq = ilv ? "R6" : "R5";
    cyc(use_c, !use_c, 1, ilv, s);
    chk("R2", s, 0);
    for (int k = 1; k <= 4; k++) begin
      cyc(1, 1, 0, flip ? !ilv : ilv, '0);
      chk(k == 4 ? "R8" : rq, exp_addr(s, k % 4, ilv), (k % 4) == 3);
      if (k == 2) begin
        cyc(1, 1, 1, !ilv, 17'h0AAAA);
        chk("R4", exp_addr(s, 2, ilv), 0);
      end
    end
    if (flip) chk("R11", exp_addr(s, 0, ilv), 0);
    if (ba[AW-1:2] !== s[AW-1:2]) begin
      checks++; errors++;
      $display("FAIL R7: upper %h expected %h", ba[AW-1:2], s[AW-1:2]);
    end else checks++;
  endtask

  task automatic t_all_starts();
    for (int m = 0; m < 2; m++)
      for (int lo = 0; lo < 4; lo++)
        t_burst({15'h2C3A, 2'(lo)}, m[0], lo[0], 0);
  endtask

  task automatic t_reload();
    cyc(0, 1, 1, 0, 17'h1ABCD);
    cyc(1, 1, 0, 0, '0);
    chk("R3", 17'h1ABCE, 0);
    cyc(1, 0, 0, 1, 17'h0F0F2);
    chk("R9", 17'h0F0F2, 0);
    cyc(1, 1, 0, 0, '0);
    chk("R9", 17'h0F0F3, 0);
  endtask

  initial begin
    t_reset();
    t_idle_advance();
    t_burst(17'h1ABCD, 0, 0, 0);
    t_burst(17'h0F0F2, 1, 1, 1);
    t_burst(17'h05551, 0, 0, 1);
    t_all_starts();
    t_reload();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule